// File: doc/BRIEF.md
# One-Time-Programmable Array Command Sequencer

This block takes commands from software for a one-time-programmable storage array and runs them against the storage macro. The operand registers hold an 11-bit byte address and two 32-bit write data words. A command is a one-shot write that asks for a read, a program (write) or a digest computation. The block finds the partition that the address falls in. It aligns the address to that partition's access size (32 or 64 bits), checks the partition's lock inputs, and then either refuses the command with an error code or raises a request toward the macro. The request stays up until the macro acknowledges it.

While a request is outstanding, the block drops the register write-enable. Any writes to the address, data or command registers are then lost, so the operands cannot change under a running operation. Every command that ends, whether by acknowledge or by refusal, gives a one-cycle completion pulse. Read results are kept in a 64-bit read data register.

Partition map (byte addresses; the granule and the digest permission are fixed):

| Index | Range | Granule | Digest allowed |
|---|---|---|---|
| 0 | 0x000-0x1FF | 32 | no |
| 1 | 0x200-0x3FF | 32 | no |
| 2 | 0x400-0x4FF | 32 | yes |
| 3 | 0x500-0x5FF | 32 | no |
| 4 | 0x600-0x67F | 64 | yes |
| 5 | 0x680-0x6FF | 64 | yes |
| 6 | 0x700-0x77F | 64 | yes |

Addresses 0x780-0x7FF are not mapped.

Top module: `fcs_seq`

## Requirements
- R1: The command register is decoded as follows: bit 0 requests a read, bit 1 a write and bit 2 a digest. The command reaches the macro on `mac_op_o` as 0 for read, 1 for write and 2 for digest. A command write of all zeros has no effect.
- R2: For a read or write, the partition comes from the map above. `mac_size64_o` is set for 64-bit partitions. The macro address has bits 1:0 cleared for a 32-bit partition and bits 2:0 cleared for a 64-bit partition.
- R3: For a digest, the address register holds a partition index, and only indices 2, 4, 5 and 6 are accepted. The macro then gets the base address of that partition, with `mac_size64_o` set and zero write data.
- R4: A 64-bit write sends {word1, word0} on `mac_wdata_o`. A 32-bit write sends word0 with the upper 32 bits zero. A read sends zero data.
- R5: `regwen_o` is 1 after reset and is 0 from the cycle after a command launches until the acknowledge. Address, data and command writes made while it is 0 are dropped.
- R6: `done_o` is high for exactly the one cycle after a command ends, whether the command ended by the macro's acknowledge or by being refused at once.
- R7: A command with more than one bit set, or a digest on an index not listed in R3, gives error code 8. A read of a partition whose `rd_lock_i` bit is set, a write or digest on a partition whose `wr_lock_i` bit is set, or an access to an unmapped address gives code 9. A refused command raises no request. The code stays until the next non-zero command write is accepted, which clears it to 0 when that command launches.
- R8: A write that is acknowledged with `mac_err_i` high gives error code 6. `mac_err_i` is ignored for reads and digests.
- R9: `idle_o` is high whenever no macro request is outstanding.
- R10: `rdata_o` resets to 0 and loads only when a read is acknowledged. A 32-bit read zeroes the upper word.
- R11: `mac_req_o` stays high, with op, address, size and write data stable, until the cycle in which `mac_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Write strobe for the address register |
| addr_i | input | 11 | New address or digest index |
| wdata_we_i | input | 2 | Write strobes for data word 0 and word 1 |
| wdata_i | input | 32 | New data word value |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 3 | Command bits: read, write, digest |
| rd_lock_i | input | 7 | Read lock per partition |
| wr_lock_i | input | 7 | Write lock per partition |
| regwen_o | output | 1 | Operand and command registers writable |
| idle_o | output | 1 | No command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 4 | Error code (0, 6, 8, 9) |
| rdata_o | output | 64 | Read data register |
| mac_req_o | output | 1 | Macro request |
| mac_op_o | output | 2 | Macro operation |
| mac_addr_o | output | 11 | Aligned macro byte address |
| mac_size64_o | output | 1 | 64-bit access |
| mac_wdata_o | output | 64 | Macro write data |
| mac_ack_i | input | 1 | Macro acknowledge |
| mac_err_i | input | 1 | Blank-check failure, valid with acknowledge on writes |
| mac_rdata_i | input | 64 | Macro read data, valid with acknowledge |

## Verification
The assertions check on every cycle that the following hold:
- the request is held with stable operands until the acknowledge;
- the macro address is aligned to the access size;
- the upper word of a 32-bit write is zero;
- the write-enable is low while a request is pending;
- the read data register changes only on a read acknowledge;
- an acknowledge is always followed by a done pulse.

Only the bench scenarios can show which partition and granule a given address selects, the accepted digest indices, the choice among error codes 6, 8 and 9, the clearing of an error by the next command, and that operand writes made during a long operation are truly lost.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int ADDR_W   = 11;
  localparam int NUM_PART = 7;
  localparam int PIDX_W   = $clog2(NUM_PART);
  localparam int CMD_W    = 3;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_DIGEST = 2'd2
  } mac_op_e;

  typedef enum logic [3:0] {
    ERR_NONE   = 4'd0,
    ERR_BLANK  = 4'd6,
    ERR_CMD    = 4'd8,
    ERR_LOCKED = 4'd9
  } err_code_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              wide;
    logic              digest_ok;
  } part_desc_t;

  // Fixed partition table.
  function automatic part_desc_t part_desc(input int unsigned idx);
    part_desc_t d;
    case (idx)
      0:       d = '{base: 11'h000, limit: 11'h1FF, wide: 1'b0, digest_ok: 1'b0};
      1:       d = '{base: 11'h200, limit: 11'h3FF, wide: 1'b0, digest_ok: 1'b0};
      2:       d = '{base: 11'h400, limit: 11'h4FF, wide: 1'b0, digest_ok: 1'b1};
      3:       d = '{base: 11'h500, limit: 11'h5FF, wide: 1'b0, digest_ok: 1'b0};
      4:       d = '{base: 11'h600, limit: 11'h67F, wide: 1'b1, digest_ok: 1'b1};
      5:       d = '{base: 11'h680, limit: 11'h6FF, wide: 1'b1, digest_ok: 1'b1};
      6:       d = '{base: 11'h700, limit: 11'h77F, wide: 1'b1, digest_ok: 1'b1};
      default: d = '{base: '0, limit: '0, wide: 1'b0, digest_ok: 1'b0};
    endcase
    return d;
  endfunction

  // Clears the address bits below the access granule.
  function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                   input logic wide);
    return wide ? {a[ADDR_W-1:3], 3'b000} : {a[ADDR_W-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/fcs_part_lookup.sv
module fcs_part_lookup
  import fcs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [PIDX_W-1:0] idx_o,
  output logic              wide_o
);

  logic [NUM_PART-1:0] match;

  for (genvar g = 0; g < NUM_PART; g++) begin : g_match
    localparam part_desc_t D = part_desc(g);
    assign match[g] = (addr_i >= D.base) && (addr_i <= D.limit);
  end

  always_comb begin
    part_desc_t d;
    hit_o  = 1'b0;
    idx_o  = '0;
    wide_o = 1'b0;
    for (int i = NUM_PART - 1; i >= 0; i--) begin
      d = part_desc(i);
      if (match[i]) begin
        hit_o  = 1'b1;
        idx_o  = PIDX_W'(i);
        wide_o = d.wide;
      end
    end
  end

endmodule

// File: rtl/fcs_cmd_check.sv
module fcs_cmd_check
  import fcs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wd_lo_i,
  input  logic [DATA_W-1:0]   wd_hi_i,
  input  logic [NUM_PART-1:0] rd_lock_i,
  input  logic [NUM_PART-1:0] wr_lock_i,
  output logic                launch_o,
  output err_code_e           err_o,
  output mac_op_e             op_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic                wide_o,
  output logic [2*DATA_W-1:0] req_wdata_o
);

  logic              hit;
  logic [PIDX_W-1:0] pidx;
  logic              pwide;

  fcs_part_lookup u_lookup (
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (pidx),
    .wide_o (pwide)
  );

  logic is_read, is_write, is_digest, multi;
  assign is_read   = cmd_i[0];
  assign is_write  = cmd_i[1];
  assign is_digest = cmd_i[2];
  assign multi     = $countones(cmd_i) > 1;

  logic              dig_in_range;
  logic [PIDX_W-1:0] dig_idx;
  assign dig_in_range = addr_i < ADDR_W'(NUM_PART);
  assign dig_idx      = addr_i[PIDX_W-1:0];

  always_comb begin
    part_desc_t dd;
    dd          = part_desc(int'(dig_idx));
    launch_o    = 1'b0;
    err_o       = ERR_NONE;
    op_o        = OP_READ;
    req_addr_o  = '0;
    wide_o      = 1'b0;
    req_wdata_o = '0;
    if (multi) begin
      err_o = ERR_CMD;
    end else if (is_digest) begin
      if (!dig_in_range || !dd.digest_ok) begin
        err_o = ERR_CMD;
      end else if (wr_lock_i[dig_idx]) begin
        err_o = ERR_LOCKED;
      end else begin
        launch_o   = 1'b1;
        op_o       = OP_DIGEST;
        req_addr_o = dd.base;
        wide_o     = 1'b1;
      end
    end else if (is_read || is_write) begin
      if (!hit || (is_read ? rd_lock_i[pidx] : wr_lock_i[pidx])) begin
        err_o = ERR_LOCKED;
      end else begin
        launch_o   = 1'b1;
        op_o       = is_read ? OP_READ : OP_WRITE;
        req_addr_o = align_addr(addr_i, pwide);
        wide_o     = pwide;
        if (is_write) begin
          req_wdata_o = pwide ? {wd_hi_i, wd_lo_i} : {{DATA_W{1'b0}}, wd_lo_i};
        end
      end
    end
  end

endmodule

// File: rtl/fcs_operand_regs.sv
module fcs_operand_regs
  import fcs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    open_i,
  input  logic                    addr_we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORDS-1:0]        data_we_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [ADDR_W-1:0]       addr_q_o,
  output logic [WORDS*DATA_W-1:0] data_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
    end else if (open_i && addr_we_i) begin
      addr_q_o <= addr_i;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q_o[w*DATA_W +: DATA_W] <= '0;
      end else if (open_i && data_we_i[w]) begin
        data_q_o[w*DATA_W +: DATA_W] <= data_i;
      end
    end
  end

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          wdata_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                cmd_we_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [NUM_PART-1:0] rd_lock_i,
  input  logic [NUM_PART-1:0] wr_lock_i,
  output logic                regwen_o,
  output logic                idle_o,
  output logic                done_o,
  output logic [3:0]          err_code_o,
  output logic [2*DATA_W-1:0] rdata_o,
  output logic                mac_req_o,
  output logic [1:0]          mac_op_o,
  output logic [ADDR_W-1:0]   mac_addr_o,
  output logic                mac_size64_o,
  output logic [2*DATA_W-1:0] mac_wdata_o,
  input  logic                mac_ack_i,
  input  logic                mac_err_i,
  input  logic [2*DATA_W-1:0] mac_rdata_i
);

  localparam int WORDS = 2;
  localparam int DW2   = WORDS * DATA_W;

  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e            state_q;
  logic              open;
  logic [ADDR_W-1:0] addr_q;
  logic [DW2-1:0]    data_q;

  assign open = (state_q == ST_IDLE);

  fcs_operand_regs #(.DATA_W(DATA_W), .WORDS(WORDS)) u_ops (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open),
    .addr_we_i (addr_we_i),
    .addr_i    (addr_i),
    .data_we_i (wdata_we_i),
    .data_i    (wdata_i),
    .addr_q_o  (addr_q),
    .data_q_o  (data_q)
  );

  logic              chk_launch;
  err_code_e         chk_err;
  mac_op_e           chk_op;
  logic [ADDR_W-1:0] chk_addr;
  logic              chk_wide;
  logic [DW2-1:0]    chk_wdata;

  fcs_cmd_check #(.DATA_W(DATA_W)) u_check (
    .cmd_i       (cmd_i),
    .addr_i      (addr_q),
    .wd_lo_i     (data_q[DATA_W-1:0]),
    .wd_hi_i     (data_q[DW2-1:DATA_W]),
    .rd_lock_i   (rd_lock_i),
    .wr_lock_i   (wr_lock_i),
    .launch_o    (chk_launch),
    .err_o       (chk_err),
    .op_o        (chk_op),
    .req_addr_o  (chk_addr),
    .wide_o      (chk_wide),
    .req_wdata_o (chk_wdata)
  );

  // Named events for the checker.
  logic cmd_fire, launch_evt, refuse_evt, complete_evt;
  assign cmd_fire     = open && cmd_we_i && (cmd_i != '0);
  assign launch_evt   = cmd_fire && chk_launch;
  assign refuse_evt   = cmd_fire && !chk_launch;
  assign complete_evt = (state_q == ST_BUSY) && mac_ack_i;

  mac_op_e           op_q;
  logic [ADDR_W-1:0] maddr_q;
  logic              wide_q;
  logic [DW2-1:0]    mwdata_q;
  logic [DW2-1:0]    rdata_q;
  err_code_e         err_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_READ;
      maddr_q  <= '0;
      wide_q   <= 1'b0;
      mwdata_q <= '0;
      rdata_q  <= '0;
      err_q    <= ERR_NONE;
      done_q   <= 1'b0;
    end else begin
      done_q <= refuse_evt || complete_evt;
      if (refuse_evt) begin
        err_q <= chk_err;
      end else if (launch_evt) begin
        err_q    <= ERR_NONE;
        state_q  <= ST_BUSY;
        op_q     <= chk_op;
        maddr_q  <= chk_addr;
        wide_q   <= chk_wide;
        mwdata_q <= chk_wdata;
      end else if (complete_evt) begin
        state_q <= ST_IDLE;
        if (op_q == OP_READ) begin
          rdata_q <= wide_q ? mac_rdata_i
                            : {{DATA_W{1'b0}}, mac_rdata_i[DATA_W-1:0]};
        end
        if (op_q == OP_WRITE && mac_err_i) begin
          err_q <= ERR_BLANK;
        end
      end
    end
  end

  assign regwen_o     = open;
  assign idle_o       = open;
  assign done_o       = done_q;
  assign err_code_o   = err_q;
  assign rdata_o      = rdata_q;
  assign mac_req_o    = (state_q == ST_BUSY);
  assign mac_op_o     = op_q;
  assign mac_addr_o   = maddr_q;
  assign mac_size64_o = wide_q;
  assign mac_wdata_o  = mwdata_q;

endmodule

// File: rtl/fcs_seq_chk.sv
module fcs_seq_chk
  import fcs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                regwen_o,
  input logic                idle_o,
  input logic                done_o,
  input logic [3:0]          err_code_o,
  input logic [2*DATA_W-1:0] rdata_o,
  input logic                mac_req_o,
  input logic [1:0]          mac_op_o,
  input logic [ADDR_W-1:0]   mac_addr_o,
  input logic                mac_size64_o,
  input logic [2*DATA_W-1:0] mac_wdata_o,
  input logic                mac_ack_i,
  input logic                launch_evt
);

  AST_BUSY_LOCKS_REGWEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o |-> !regwen_o); // R5

  AST_REQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o && !mac_ack_i |=> mac_req_o && $stable(mac_addr_o) && $stable(mac_wdata_o)
                                && $stable(mac_op_o) && $stable(mac_size64_o)); // R11

  AST_ALIGN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o |-> mac_addr_o[1:0] == 2'b00); // R2

  AST_ALIGN_DWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o && mac_size64_o |-> mac_addr_o[2:0] == 3'b000); // R2

  AST_NARROW_WDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o && !mac_size64_o |-> mac_wdata_o[2*DATA_W-1:DATA_W] == '0); // R4

  AST_ACK_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o && mac_ack_i |=> done_o && idle_o); // R6

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mac_req_o); // R9

  AST_LAUNCH_CLEARS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_evt |=> mac_req_o && err_code_o == 4'd0); // R7

  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mac_req_o && mac_ack_i && mac_op_o == 2'd0) |=> $stable(rdata_o)); // R10

  AST_NARROW_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o && mac_ack_i && mac_op_o == 2'd0 && !mac_size64_o
      |=> rdata_o[2*DATA_W-1:DATA_W] == '0); // R10

endmodule

bind fcs_seq fcs_seq_chk #(.DATA_W(DATA_W)) u_fcs_seq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .regwen_o     (regwen_o),
  .idle_o       (idle_o),
  .done_o       (done_o),
  .err_code_o   (err_code_o),
  .rdata_o      (rdata_o),
  .mac_req_o    (mac_req_o),
  .mac_op_o     (mac_op_o),
  .mac_addr_o   (mac_addr_o),
  .mac_size64_o (mac_size64_o),
  .mac_wdata_o  (mac_wdata_o),
  .mac_ack_i    (mac_ack_i),
  .launch_evt   (launch_evt)
);

// File: tb/test_fcs_seq.sv
module test_fcs_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_we = 1'b0;
  logic [10:0] addr_in = '0;
  logic [1:0]  wdata_we = '0;
  logic [31:0] wdata_in = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_in = '0;
  logic [6:0]  rd_lock = '0;
  logic [6:0]  wr_lock = '0;
  logic        ack = 1'b0;
  logic        merr = 1'b0;
  logic [63:0] mrdata = '0;

  logic        regwen, idle, done, req, size64;
  logic [3:0]  err_code;
  logic [63:0] rdata, wdata_out;
  logic [1:0]  op;
  logic [10:0] maddr;

  fcs_seq i_fcs_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_we_i(addr_we), .addr_i(addr_in),
    .wdata_we_i(wdata_we), .wdata_i(wdata_in),
    .cmd_we_i(cmd_we), .cmd_i(cmd_in),
    .rd_lock_i(rd_lock), .wr_lock_i(wr_lock),
    .regwen_o(regwen), .idle_o(idle), .done_o(done),
    .err_code_o(err_code), .rdata_o(rdata),
    .mac_req_o(req), .mac_op_o(op), .mac_addr_o(maddr),
    .mac_size64_o(size64), .mac_wdata_o(wdata_out),
    .mac_ack_i(ack), .mac_err_i(merr), .mac_rdata_i(mrdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int ack_delay = 0;
  bit blank_fail = 0;
  bit started = 0;

  // Reference model state
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_op = 0;
  logic [10:0] m_maddr = '0;
  bit          m_wide = 0;
  logic [63:0] m_wdata = '0;
  logic [63:0] m_rdata = '0;
  int          m_err = 0;
  logic [10:0] m_a = '0;
  logic [31:0] m_w0 = '0, m_w1 = '0;

  function automatic int ref_part(input logic [10:0] a);
    if (a < 11'h200) return 0;
    if (a < 11'h400) return 1;
    if (a < 11'h500) return 2;
    if (a < 11'h600) return 3;
    if (a < 11'h680) return 4;
    if (a < 11'h700) return 5;
    if (a < 11'h780) return 6;
    return -1;
  endfunction

  function automatic logic [10:0] ref_base(input int p);
    logic [10:0] b [7] = '{11'h000, 11'h200, 11'h400, 11'h500, 11'h600, 11'h680, 11'h700};
    return b[p];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_op = 0; m_maddr = '0; m_wide = 0;
      m_wdata = '0; m_rdata = '0; m_err = 0; m_a = '0; m_w0 = '0; m_w1 = '0;
    end else begin
      bit nd;
      nd = 0;
      if (m_busy) begin
        if (ack) begin
          m_busy = 0; nd = 1;
          if (m_op == 0) m_rdata = m_wide ? mrdata : {32'h0, mrdata[31:0]};
          if (m_op == 1 && merr) m_err = 6;
        end
      end else begin
        if (cmd_we && cmd_in != 0) begin
          int e, p;
          e = 0;
          nd = 1;
          if ($countones(cmd_in) > 1) e = 8;
          else if (cmd_in[2]) begin
            if (m_a == 2 || m_a == 4 || m_a == 5 || m_a == 6) begin
              p = int'(m_a);
              if (wr_lock[p]) e = 9;
              else begin
                m_op = 2; m_maddr = ref_base(p); m_wide = 1; m_wdata = '0;
              end
            end else e = 8;
          end else begin
            p = ref_part(m_a);
            if (p < 0) e = 9;
            else if (cmd_in[0] && rd_lock[p]) e = 9;
            else if (cmd_in[1] && wr_lock[p]) e = 9;
            else begin
              m_wide  = (p >= 4);
              m_op    = cmd_in[0] ? 0 : 1;
              m_maddr = m_wide ? (m_a & 11'h7F8) : (m_a & 11'h7FC);
              m_wdata = (m_op == 0) ? 64'h0 : (m_wide ? {m_w1, m_w0} : {32'h0, m_w0});
            end
          end
          if (e != 0) m_err = e;
          else begin m_err = 0; m_busy = 1; nd = 0; end
        end
        if (addr_we) m_a = addr_in;
        if (wdata_we[0]) m_w0 = wdata_in;
        if (wdata_we[1]) m_w1 = wdata_in;
      end
      m_done = nd;
      started = 1;
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      cmp("R5 regwen", 64'(regwen), 64'(!m_busy));
      cmp("R9 idle", 64'(idle), 64'(!m_busy));
      cmp("R6 done", 64'(done), 64'(m_done));
      cmp("R7 R8 err_code", 64'(err_code), 64'(m_err));
      cmp("R10 rdata", rdata, m_rdata);
      cmp("R11 req", 64'(req), 64'(m_busy));
      if (m_busy) begin
        cmp("R1 op", 64'(op), 64'(m_op));
        cmp("R2 R3 addr", 64'(maddr), 64'(m_maddr));
        cmp("R2 size64", 64'(size64), 64'(m_wide));
        cmp("R4 wdata", wdata_out, m_wdata);
      end
    end
  end

  // Macro responder
  int cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 0; cnt = 0;
    end else if (ack) begin
      ack = 0; merr = 0;
    end else if (req) begin
      if (cnt >= ack_delay) begin
        ack = 1;
        merr = blank_fail;
        mrdata = {21'h1A5A5, maddr, 21'h0F0F0, ~maddr};
        cnt = 0;
      end else cnt++;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      mismatched++;
      $display("FAIL R9 watchdog: actual=busy expected=idle");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic set_addr(input logic [10:0] a);
    @(negedge clk); addr_we = 1; addr_in = a;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic set_data(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); wdata_we = 2'b01; wdata_in = lo;
    @(negedge clk); wdata_we = 2'b10; wdata_in = hi;
    @(negedge clk); wdata_we = 2'b00;
  endtask

  task automatic pulse_cmd(input logic [2:0] c);
    @(negedge clk); cmd_we = 1; cmd_in = c;
    @(negedge clk); cmd_we = 0; cmd_in = '0;
  endtask

  task automatic run(input logic [10:0] a, input logic [2:0] c);
    set_addr(a);
    pulse_cmd(c);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R10 R5 reset state is covered by the first comparisons
    ack_delay = 2;
    run(11'h013, 3'b001);                 // R2 32-bit read, misaligned
    run(11'h605, 3'b001);                 // R2 64-bit read
    set_data(32'hDEADBEEF, 32'h01234567);
    ack_delay = 0;
    run(11'h106, 3'b010);                 // R4 32-bit write
    run(11'h6A9, 3'b010);                 // R4 64-bit write
    blank_fail = 1;
    run(11'h204, 3'b010);                 // R8 blank-check failure
    run(11'h204, 3'b001);                 // R8 read ignores the error input
    blank_fail = 0;
    run(11'h010, 3'b011);                 // R7 multi-bit command
    pulse_cmd(3'b000);                    // R1 zero command, no effect
    repeat (3) @(negedge clk);
    run(11'h010, 3'b001);                 // R7 cleared on launch
    run(11'h003, 3'b100);                 // R3 digest index not allowed
    run(11'h005, 3'b100);                 // R3 digest accepted
    run(11'h002, 3'b100);                 // R3 digest on 32-bit partition
    rd_lock = 7'b0000010;
    run(11'h300, 3'b001);                 // R7 read-locked
    wr_lock = 7'b0010000;
    run(11'h610, 3'b010);                 // R7 write-locked
    run(11'h610, 3'b001);                 // R7 read allowed on write-locked
    run(11'h004, 3'b100);                 // R7 digest on locked partition
    run(11'h7C0, 3'b001);                 // R7 unmapped
    rd_lock = '0; wr_lock = '0;
    // R5 writes while busy are dropped
    ack_delay = 14;
    set_addr(11'h024);
    pulse_cmd(3'b001);
    set_addr(11'h7FF);
    set_data(32'h11111111, 32'h22222222);
    pulse_cmd(3'b010);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    ack_delay = 1;
    pulse_cmd(3'b010);                    // R5 uses the earlier operands
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule